// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Holding Register

This block takes a serial line and a stream of half-bit ticks from an external baud generator, and turns the line into words for software. Two start modes exist. In framed mode a falling edge on the idle line begins a character with a start bit and a stop bit. The line is sampled at the middle of each bit. In free-running mode there are no start or stop bits. Software enables the receiver, which locks its sampling phase to that moment and keeps sampling until it is disabled. It hands over a complete word every 32 bits. A pulse on the resync input locks the phase again at any time.

Every delivered word lands in one holding register with a ready flag, so software has a whole character or word time to collect it. The level seen at the stop-bit sample is kept next to the data for break detection. A word that arrives while the previous one is still unread raises an overrun flag.

Top module: `sar_rx`

## Requirements
- R1: After reset, rd_ready and rd_overrun are 0, rd_data is all zeros and rd_stop is 1.
- R2: With rx_en=1 and sw_mode=0, a high-to-low change of rx_in starts a character. The first half_tick after it is the mid-start check. If rx_in is high at that check, the character is dropped as a glitch and nothing is delivered.
- R3: In framed mode, each later sample falls on the second half_tick after the previous sample. Samples 1 to 8 are the data bits, least significant bit first. They are delivered in rd_data[7:0], and rd_data[31:8] is zero.
- R4: The tenth framed sample is the mid-stop sample. At that sample the character is delivered and rd_ready is set. rx_in at that instant is stored in rd_stop, whether it is 1 or 0, and a character with a low stop level is still delivered.
- R5: A rising rx_en while sw_mode=1 locks free-running mode. The first half_tick afterwards samples, and later samples come on every second half_tick. After 32 samples the word is delivered, with the first sample in bit 0. rd_stop is not changed.
- R6: A resync pulse while rx_en=1 and sw_mode=1 discards the partial word and relocks the phase, so the next half_tick is again a sample.
- R7: While rx_en=0 nothing is sampled or delivered, and a partial word is discarded. Line edges are ignored.
- R8: A rd_strobe cycle clears rd_ready one cycle later. rd_data changes only when a word is delivered.
- R9: A word completing while rd_ready=1 and rd_strobe=0 sets rd_overrun and leaves rd_data unchanged. If rd_strobe is high in that same cycle, the new word is loaded and rd_ready stays 1. rd_strobe clears rd_overrun.
- R10: In free-running mode, consecutive words follow each other with no lost or repeated samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_in | input | 1 | Serial line, idle high |
| half_tick | input | 1 | One-cycle pulse every half bit time |
| rx_en | input | 1 | Receiver enable |
| sw_mode | input | 1 | 1 selects free-running unframed mode, 0 selects framed mode |
| resync | input | 1 | Relocks the phase in free-running mode |
| rd_strobe | input | 1 | Software read of the holding register |
| rd_ready | output | 1 | Holding register holds an unread word |
| rd_data | output | 32 | Holding register contents |
| rd_stop | output | 1 | Line level at the last mid-stop sample |
| rd_overrun | output | 1 | A word was lost while rd_ready was set |

## Verification
The bench sweeps every 8-bit value through framed mode with alternating stop levels. A wrong bit order or an off-by-one-tick sample point corrupts the data of many of those values. Resync is pulsed right after a sample tick. A design that keeps its old half-bit phase then samples on the wrong tick and returns a shifted word. The bench also covers a start pulse that is gone at mid-start (a design without glitch rejection delivers a spurious character) and a low stop level (which must still deliver and report 0). It checks overrun against a read that lands in the same cycle as a delivery, where a wrong priority would either lose the new word or raise a false overrun.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FRAMED = 2'd1,
    ST_FREE   = 2'd2
  } rx_state_e;

  // Index width for a sample counter that must reach max(word, char+2) values
  function automatic int idx_bits(input int word_w, input int char_w);
    int m;
    m = (word_w > char_w + 2) ? word_w : char_w + 2;
    return $clog2(m);
  endfunction
endpackage

// File: rtl/sar_phase.sv
module sar_phase #(
  parameter int IDX_W = 5,
  parameter int LAST  = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             tick,
  input  logic             active,
  output logic             sample_evt,
  output logic [IDX_W-1:0] idx
);
  logic ph;

  assign sample_evt = tick & active & ~ph;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      ph  <= 1'b0;
      idx <= '0;
    end else if (tick && active) begin
      ph <= ~ph;
      if (!ph) idx <= (idx == IDX_W'(LAST)) ? '0 : idx + 1'b1;
    end
  end
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int CHAR_W = 8,
  parameter int WORD_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             mode,
  input  logic             en_rise,
  input  logic             restart,
  input  logic             fall_edge,
  input  logic             rx_in,
  input  logic             sample_evt,
  input  logic [IDX_W-1:0] idx,
  output logic             clear,
  output logic             active,
  output logic             shift_en,
  output logic             deliver,
  output logic             glitch,
  output logic             stop_we,
  output logic             free_mode
);
  localparam logic [IDX_W-1:0] STOP_IDX = IDX_W'(CHAR_W + 1);
  localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(CHAR_W);
  localparam logic [IDX_W-1:0] WORD_END = IDX_W'(WORD_W - 1);

  rx_state_e state, nxt;
  logic lock, ok, framed, frame_end, free_end, data_idx;

  assign framed    = (state == ST_FRAMED);
  assign free_mode = (state == ST_FREE);
  assign active    = (state != ST_IDLE);
  assign lock      = enable & mode & (en_rise | restart);
  assign ok        = enable & ~lock;
  assign data_idx  = (idx != '0) && (idx <= LAST_BIT);
  assign glitch    = sample_evt & framed & (idx == '0) & rx_in;
  assign frame_end = sample_evt & framed & (idx == STOP_IDX);
  assign free_end  = sample_evt & free_mode & (idx == WORD_END);
  assign deliver   = ok & (frame_end | free_end);
  assign stop_we   = ok & frame_end;
  assign shift_en  = ok & sample_evt & ((framed & data_idx) | free_mode);

  always_comb begin
    nxt   = state;
    clear = 1'b0;
    if (!enable) begin
      nxt = ST_IDLE;
    end else if (lock) begin
      nxt   = ST_FREE;
      clear = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: if (!mode && fall_edge) begin
          nxt   = ST_FRAMED;
          clear = 1'b1;
        end
        ST_FRAMED: if (glitch || frame_end) nxt = ST_IDLE;
        ST_FREE:   if (!mode) nxt = ST_IDLE;
        default:   nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/sar_shift.sv
module sar_shift #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [WORD_W-1:0] sh
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear) sh <= '0;
    else if (shift_en)   sh <= {bit_in, sh[WORD_W-1:1]};
  end
endmodule

// File: rtl/sar_hold.sv
module sar_hold #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              deliver,
  input  logic [WORD_W-1:0] word_in,
  input  logic              stop_we,
  input  logic              stop_in,
  input  logic              rd,
  output logic              rdy,
  output logic [WORD_W-1:0] data,
  output logic              stop,
  output logic              ovr,
  output logic              overrun_evt
);
  assign overrun_evt = deliver & rdy & ~rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy  <= 1'b0;
      data <= '0;
      stop <= 1'b1;
      ovr  <= 1'b0;
    end else if (overrun_evt) begin
      ovr <= 1'b1;
    end else if (deliver) begin
      rdy  <= 1'b1;
      data <= word_in;
      if (stop_we) stop <= stop_in;
      if (rd) ovr <= 1'b0;
    end else if (rd) begin
      rdy <= 1'b0;
      ovr <= 1'b0;
    end
  end
endmodule

// File: rtl/sar_rx.sv
module sar_rx #(
  parameter int WORD_W = 32,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_in,
  input  logic              half_tick,
  input  logic              rx_en,
  input  logic              sw_mode,
  input  logic              resync,
  input  logic              rd_strobe,
  output logic              rd_ready,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_stop,
  output logic              rd_overrun
);
  localparam int IDX_W = sar_pkg::idx_bits(WORD_W, CHAR_W);

  logic rx_prev, en_prev, en_rise, fall_edge;
  logic clear, active, shift_en, deliver, glitch, stop_we, free_mode;
  logic sample_evt, overrun_evt;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] sh, word_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_prev <= 1'b1;
      en_prev <= 1'b0;
    end else begin
      rx_prev <= rx_in;
      en_prev <= rx_en;
    end
  end

  assign en_rise   = rx_en & ~en_prev;
  assign fall_edge = rx_prev & ~rx_in;
  assign word_in   = free_mode ? {rx_in, sh[WORD_W-1:1]} : (sh >> (WORD_W - CHAR_W));

  sar_phase #(.IDX_W(IDX_W), .LAST(WORD_W - 1)) u_phase (
    .clk(clk), .rst_n(rst_n), .clear(clear), .tick(half_tick),
    .active(active), .sample_evt(sample_evt), .idx(idx)
  );

  sar_ctrl #(.IDX_W(IDX_W), .CHAR_W(CHAR_W), .WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(rx_en), .mode(sw_mode),
    .en_rise(en_rise), .restart(resync), .fall_edge(fall_edge),
    .rx_in(rx_in), .sample_evt(sample_evt), .idx(idx),
    .clear(clear), .active(active), .shift_en(shift_en),
    .deliver(deliver), .glitch(glitch), .stop_we(stop_we),
    .free_mode(free_mode)
  );

  sar_shift #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .clear(clear), .shift_en(shift_en),
    .bit_in(rx_in), .sh(sh)
  );

  sar_hold #(.WORD_W(WORD_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .deliver(deliver), .word_in(word_in),
    .stop_we(stop_we), .stop_in(rx_in), .rd(rd_strobe),
    .rdy(rd_ready), .data(rd_data), .stop(rd_stop), .ovr(rd_overrun),
    .overrun_evt(overrun_evt)
  );
endmodule

// File: rtl/sar_rx_chk.sv
module sar_rx_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rx_en,
  input logic              half_tick,
  input logic              rd_strobe,
  input logic              rd_ready,
  input logic [WORD_W-1:0] rd_data,
  input logic              rd_overrun,
  input logic              sample_evt,
  input logic              deliver,
  input logic              glitch,
  input logic              active
);
  p_sample_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |-> half_tick);

  p_glitch_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    glitch |=> !active);

  p_deliver_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    deliver |=> rd_ready);

  p_quiet_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !sample_evt);

  p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !deliver) |=> !rd_ready);

  p_data_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !deliver |=> $stable(rd_data));

  p_overrun_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_overrun) |-> $past(deliver && rd_ready && !rd_strobe));
endmodule

bind sar_rx sar_rx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .half_tick(half_tick),
  .rd_strobe(rd_strobe), .rd_ready(rd_ready), .rd_data(rd_data),
  .rd_overrun(rd_overrun), .sample_evt(sample_evt), .deliver(deliver),
  .glitch(glitch), .active(active)
);

// File: tb/tb_sar_rx.sv
module tb_sar_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_in = 1'b1, half_tick = 1'b0, rx_en = 1'b0, sw_mode = 1'b0;
  logic resync = 1'b0, rd_strobe = 1'b0;
  logic rd_ready, rd_stop, rd_overrun;
  logic [31:0] rd_data;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sar_rx dut (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .half_tick(half_tick),
    .rx_en(rx_en), .sw_mode(sw_mode), .resync(resync), .rd_strobe(rd_strobe),
    .rd_ready(rd_ready), .rd_data(rd_data), .rd_stop(rd_stop),
    .rd_overrun(rd_overrun)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one half-bit tick, optionally with a read in the same cycle
  task automatic tick(input logic r);
    @(negedge clk); half_tick = 1'b1; rd_strobe = r;
    @(negedge clk); half_tick = 1'b0; rd_strobe = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_read();
    @(negedge clk); rd_strobe = 1'b1;
    @(negedge clk); rd_strobe = 1'b0;
  endtask

  // framed character: start edge, mid-start, 8 data bits, mid-stop
  task automatic send_char(input logic [7:0] b, input logic st, input logic rd_at_stop);
    @(negedge clk); rx_in = 1'b0;
    @(negedge clk);
    tick(1'b0); tick(1'b0);
    for (int i = 0; i < 8; i++) begin
      rx_in = b[i]; tick(1'b0); tick(1'b0);
    end
    rx_in = st; tick(rd_at_stop);
    if (!st) begin
      @(negedge clk); rx_in = 1'b1;
      @(negedge clk);
    end
  endtask

  task automatic send_word(input logic [31:0] w);
    for (int i = 0; i < 32; i++) begin
      rx_in = w[i]; tick(1'b0);
      if (i != 31) tick(1'b0);
    end
  endtask

  task automatic go_framed();
    @(negedge clk); rx_en = 1'b0; sw_mode = 1'b0; rx_in = 1'b1;
    @(negedge clk); rx_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic go_free();
    @(negedge clk); rx_en = 1'b0; sw_mode = 1'b1;
    @(negedge clk); rx_en = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready", rd_ready, 0);
    chk("R1 overrun", rd_overrun, 0);
    chk("R1 data", rd_data, 0);
    chk("R1 stop", rd_stop, 1);

    // R3 R4: full sweep of characters, alternating stop level
    go_framed();
    for (int v = 0; v < 256; v++) begin
      logic st;
      st = ~(v[0] ^ v[4]);
      send_char(v[7:0], st, 1'b0);
      chk("R4 ready", rd_ready, 1);
      chk("R3 data", rd_data, {24'h0, v[7:0]});
      chk("R4 stop", rd_stop, st);
      do_read();
      chk("R8 ready cleared", rd_ready, 0);
    end

    // R2 glitch: line back high at mid-start
    @(negedge clk); rx_in = 1'b0;
    @(negedge clk);
    rx_in = 1'b1; tick(1'b0); tick(1'b0);
    for (int i = 0; i < 18; i++) tick(1'b0);
    chk("R2 glitch dropped", rd_ready, 0);
    chk("R2 data untouched", rd_data, 32'h0000_00ff);
    send_char(8'h5a, 1'b1, 1'b0);
    chk("R2 next char", rd_data, 32'h0000_005a);
    do_read();

    // R4 break: all zero with low stop
    send_char(8'h00, 1'b0, 1'b0);
    chk("R4 break ready", rd_ready, 1);
    chk("R4 break stop", rd_stop, 0);
    chk("R4 break data", rd_data, 0);
    do_read();

    // R7 disabled: edges and ticks ignored
    @(negedge clk); rx_en = 1'b0; rx_in = 1'b0;
    for (int i = 0; i < 20; i++) tick(1'b0);
    rx_in = 1'b1; @(negedge clk);
    chk("R7 disabled framed", rd_ready, 0);

    // R9 overrun: two chars unread, then read with delivery same cycle
    go_framed();
    send_char(8'h3c, 1'b1, 1'b0);
    send_char(8'hc3, 1'b1, 1'b0);
    chk("R9 overrun set", rd_overrun, 1);
    chk("R9 data kept", rd_data, 32'h0000_003c);
    chk("R9 ready kept", rd_ready, 1);
    do_read();
    chk("R9 overrun cleared", rd_overrun, 0);
    chk("R9 ready cleared", rd_ready, 0);
    send_char(8'h11, 1'b1, 1'b0);
    send_char(8'h22, 1'b0, 1'b1);
    chk("R9 same-cycle data", rd_data, 32'h0000_0022);
    chk("R9 same-cycle ready", rd_ready, 1);
    chk("R9 same-cycle no overrun", rd_overrun, 0);
    chk("R4 stop low kept", rd_stop, 0);
    do_read();

    // R5 free-running word
    go_free();
    send_word(32'hdead_beef);
    chk("R5 ready", rd_ready, 1);
    chk("R5 word", rd_data, 32'hdead_beef);
    chk("R5 stop untouched", rd_stop, 0);
    do_read();

    // R10 continuous words: spacer tick then next word
    tick(1'b0);
    send_word(32'h1234_5678);
    chk("R10 second word", rd_data, 32'h1234_5678);
    do_read();
    tick(1'b0);
    send_word(32'h8000_0001);
    chk("R10 third word", rd_data, 32'h8000_0001);
    do_read();

    // R6 resync right after a sample tick
    tick(1'b0);
    for (int i = 0; i < 7; i++) begin rx_in = i[0]; tick(1'b0); tick(1'b0); end
    rx_in = 1'b1; tick(1'b0);
    @(negedge clk); resync = 1'b1;
    @(negedge clk); resync = 1'b0;
    send_word(32'h0f0f_a5c3);
    chk("R6 resync word", rd_data, 32'h0f0f_a5c3);
    chk("R6 ready", rd_ready, 1);
    do_read();

    // R9 overrun in free mode
    tick(1'b0);
    send_word(32'haaaa_5555);
    tick(1'b0);
    send_word(32'h0000_ffff);
    chk("R9 free overrun", rd_overrun, 1);
    chk("R9 free data kept", rd_data, 32'haaaa_5555);
    do_read();

    // R7 disable mid-word discards partial
    tick(1'b0);
    for (int i = 0; i < 10; i++) begin rx_in = 1'b1; tick(1'b0); tick(1'b0); end
    @(negedge clk); rx_en = 1'b0;
    for (int i = 0; i < 4; i++) tick(1'b0);
    chk("R7 no delivery off", rd_ready, 0);
    @(negedge clk); rx_en = 1'b1;
    @(negedge clk);
    send_word(32'h7e00_00e7);
    chk("R7 fresh word", rd_data, 32'h7e00_00e7);
    do_read();

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule